// File: doc/BRIEF.md
# Mode-Filtered Traffic Log FIFO

This block keeps a short queue of bus-traffic words for the host processor. A protocol decoder upstream presents one classified word at a time: a 16-bit value, a type tag saying whether it is a data, command or status word, and two qualifier flags. The block decides, based on the terminal role it is currently playing, whether that word belongs in the log. It then stores accepted words in arrival order in a 32-entry buffer.

In the remote-terminal role it records command words that reached the main RAM, and mode-code commands that carry data and need the host. In the bus-controller role it records every status response. The role register comes out of reset in the remote-terminal role and the host can change it with a one-cycle write strobe.

The host drains the log by reading a fixed address, which returns the oldest word and removes it. Two active-low pins report the fill state: one is low while the log is empty, and the other is low while it is full.

Top module: `tlf_top`

## Requirements
- R1: While `rst` is high on a clock edge, the log is emptied and the role becomes remote terminal. After that edge `empty_n` is 0, `full_n` is 1 and `rd_data` is 0000h.
- R2: In the remote-terminal role (role bit 0), a valid word tagged command (`word_kind` = 2'b01) with `cmd_ram_hit` = 1 is stored.
- R3: In the remote-terminal role, a command word with `cmd_mc_host` = 1 is stored. A command word with both qualifiers at 0 is not stored.
- R4: In the remote-terminal role, words tagged data (2'b00), status (2'b10) or reserved (2'b11) are never stored, whatever their qualifier flags.
- R5: In the bus-controller role (role bit 1), every valid status word is stored. Command, data and reserved words are not stored, even with qualifier flags set.
- R6: A cycle with `rd_en` = 1 and `rd_addr` = 0 on a non-empty log places the oldest stored word on `rd_data` after that clock edge and removes it. Words leave in the order they were stored. `rd_data` holds its value in cycles without `rd_en`.
- R7: `empty_n` is 0 exactly when the log holds no words and 1 otherwise. It reflects the content after each clock edge.
- R8: `full_n` goes to 0 once 32 words are held. A capture attempt while the log is full and not being popped in the same cycle is dropped, and the stored contents are unchanged.
- R9: When the log is full and a pop and an accepted capture fall in the same cycle, the oldest word is returned, the new word is appended, and `full_n` stays 0.
- R10: A read of address 0 on an empty log, or a read of any non-zero address, returns 0000h on `rd_data` and removes nothing.
- R11: A cycle with `mode_wr_en` = 1 loads `mode_wr_val` into the role (0 remote terminal, 1 bus controller). A word presented in that same cycle is filtered under the previous role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_en | input | 1 | Strobe that loads the terminal role |
| mode_wr_val | input | 1 | New role: 0 remote terminal, 1 bus controller |
| word_vld | input | 1 | A classified word is presented this cycle |
| word_kind | input | 2 | Word tag: 00 data, 01 command, 10 status, 11 reserved |
| word_data | input | 16 | Word value |
| cmd_ram_hit | input | 1 | Command caused a main-RAM receive or transmit access |
| cmd_mc_host | input | 1 | Command is a mode code carrying data that needs the host |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 5 | Host read address; address 0 pops the log |
| rd_data | output | 16 | Registered read result |
| empty_n | output | 1 | Low while the log is empty |
| full_n | output | 1 | Low while the log is full |

## Verification
The hardest situation to reach from the ports is a full log that receives a pop and an accepted capture in the same cycle. In that cycle the write pointer equals the read pointer, so the read must return the old word before the new one overwrites it. Random traffic only rarely fills all 32 entries with reads mixed in. A directed phase therefore fills the log with status words in the bus-controller role, tries an extra capture, and then issues the combined cycle. Random phases that favour capture over pop then push the log repeatedly against its full boundary, under both roles and with role changes mid-stream.

// File: rtl/tlf_pkg.sv
package tlf_pkg;
  typedef enum logic [1:0] {
    WK_DATA = 2'b00,
    WK_CMD  = 2'b01,
    WK_STAT = 2'b10,
    WK_RSVD = 2'b11
  } word_kind_e;

  typedef enum logic {
    ROLE_RT = 1'b0,
    ROLE_BC = 1'b1
  } term_role_e;
endpackage

// File: rtl/tlf_capture_filter.sv
module tlf_capture_filter
  import tlf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr_en,
  input  logic       mode_wr_val,
  input  logic       word_vld,
  input  logic [1:0] word_kind,
  input  logic       cmd_ram_hit,
  input  logic       cmd_mc_host,
  output term_role_e mode_q,
  output logic       cap_req
);
  logic is_cmd;
  logic is_stat;
  logic rt_keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= ROLE_RT;
    end else if (mode_wr_en) begin
      mode_q <= mode_wr_val ? ROLE_BC : ROLE_RT;
    end
  end

  always_comb begin
    is_cmd  = (word_kind == WK_CMD);
    is_stat = (word_kind == WK_STAT);
    rt_keep = is_cmd && (cmd_ram_hit || cmd_mc_host);
    case (mode_q)
      ROLE_BC: cap_req = word_vld && is_stat;
      default: cap_req = word_vld && rt_keep;
    endcase
  end
endmodule

// File: rtl/tlf_ptr_ctrl.sv
module tlf_ptr_ctrl #(
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_req,
  input  logic             pop_req,
  output logic             do_push,
  output logic             do_pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] cnt,
  output logic             empty_n,
  output logic             full_n
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_nxt;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_pop  = pop_req && (cnt != '0);
    do_push = cap_req && ((cnt != CNT_FULL) || do_pop);
    cnt_nxt = cnt;
    if (do_push && !do_pop) begin
      cnt_nxt = cnt + 1'b1;
    end else if (do_pop && !do_push) begin
      cnt_nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      empty_n <= 1'b0;
      full_n  <= 1'b1;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      cnt     <= cnt_nxt;
      empty_n <= (cnt_nxt != '0);
      full_n  <= (cnt_nxt != CNT_FULL);
    end
  end
endmodule

// File: rtl/tlf_ram.sv
module tlf_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic              rclr,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rclr) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/tlf_top.sv
module tlf_top #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 32,
  parameter int HOST_AW  = 5,
  parameter int POP_ADDR = 0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_wr_en,
  input  logic               mode_wr_val,
  input  logic               word_vld,
  input  logic [1:0]         word_kind,
  input  logic [DATA_W-1:0]  word_data,
  input  logic               cmd_ram_hit,
  input  logic               cmd_mc_host,
  input  logic               rd_en,
  input  logic [HOST_AW-1:0] rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               empty_n,
  output logic               full_n
);
  import tlf_pkg::*;

  localparam logic [HOST_AW-1:0] POP_HIT = HOST_AW'(POP_ADDR);

  term_role_e       mode_q;
  logic             cap_req;
  logic             pop_req;
  logic             do_push;
  logic             do_pop;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt;

  assign pop_req = rd_en && (rd_addr == POP_HIT);

  tlf_capture_filter u_filter (
    .clk         (clk),
    .rst         (rst),
    .mode_wr_en  (mode_wr_en),
    .mode_wr_val (mode_wr_val),
    .word_vld    (word_vld),
    .word_kind   (word_kind),
    .cmd_ram_hit (cmd_ram_hit),
    .cmd_mc_host (cmd_mc_host),
    .mode_q      (mode_q),
    .cap_req     (cap_req)
  );

  tlf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .cap_req (cap_req),
    .pop_req (pop_req),
    .do_push (do_push),
    .do_pop  (do_pop),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .cnt     (cnt),
    .empty_n (empty_n),
    .full_n  (full_n)
  );

  tlf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (do_push),
    .waddr (wr_ptr),
    .wdata (word_data),
    .re    (do_pop),
    .rclr  (rd_en && !do_pop),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/tlf_checker.sv
module tlf_checker #(
  parameter int DATA_W  = 16,
  parameter int HOST_AW = 5,
  parameter int DEPTH   = 32,
  parameter int CNT_W   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               word_vld,
  input logic [1:0]         word_kind,
  input logic               rd_en,
  input logic [HOST_AW-1:0] rd_addr,
  input logic [DATA_W-1:0]  rd_data,
  input logic               empty_n,
  input logic               full_n,
  input logic [CNT_W-1:0]   cnt,
  input logic               mode_q
);
  // R1: reset leaves the log empty and not full
  p_reset_state_r1: assert property (@(posedge clk) rst |=> (!empty_n && full_n && rd_data == '0));

  // R7 and R8: the two flags never claim empty and full at once
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst) !(!empty_n && !full_n));

  // R8: the occupancy never exceeds the depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(DEPTH));

  // R8: a full log without a read stays full
  p_full_hold_r8: assert property (@(posedge clk) disable iff (rst) (!full_n && !rd_en) |=> !full_n);

  // R9: full log, pop plus accepted status capture in bus-controller role keeps it full
  p_full_swap_r9: assert property (@(posedge clk) disable iff (rst)
    (!full_n && rd_en && rd_addr == '0 && word_vld && word_kind == 2'b10 && mode_q) |=> !full_n);

  // R6: a pop with no capture lowers the occupancy by one
  p_pop_dec_r6: assert property (@(posedge clk) disable iff (rst)
    (empty_n && rd_en && rd_addr == '0 && !word_vld) |=> (cnt == $past(cnt) - 1'b1));

  // R10: an empty read returns zero
  p_empty_read_r10: assert property (@(posedge clk) disable iff (rst) (!empty_n && rd_en) |=> rd_data == '0);

  // R10: a non-zero address returns zero and does not change the occupancy
  p_other_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != '0 && !word_vld) |=> (rd_data == '0 && $stable(cnt)));
endmodule

bind tlf_top tlf_checker #(
  .DATA_W(DATA_W), .HOST_AW(HOST_AW), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_vld  (word_vld),
  .word_kind (word_kind),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .empty_n   (empty_n),
  .full_n    (full_n),
  .cnt       (cnt),
  .mode_q    (mode_q)
);

// File: tb/tlf_top_tb.sv
`timescale 1ns/1ps
module tlf_top_tb;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr_en = 1'b0;
  logic        mode_wr_val = 1'b0;
  logic        word_vld = 1'b0;
  logic [1:0]  word_kind = 2'b00;
  logic [15:0] word_data = '0;
  logic        cmd_ram_hit = 1'b0;
  logic        cmd_mc_host = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        empty_n;
  logic        full_n;

  int checks = 0;
  int errors = 0;
  logic [15:0] q[$];
  logic        m_role = 1'b0;
  logic [15:0] m_rd = '0;

  always #10 clk = ~clk;

  tlf_top u_dut (
    .clk(clk), .rst(rst), .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
    .word_vld(word_vld), .word_kind(word_kind), .word_data(word_data),
    .cmd_ram_hit(cmd_ram_hit), .cmd_mc_host(cmd_mc_host),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .empty_n(empty_n), .full_n(full_n)
  );

  // Acceptance rule taken from R2..R5
  function automatic logic keep_word(input logic role, input logic v, input logic [1:0] k,
                                     input logic ram, input logic mc);
    if (!v) return 1'b0;
    if (role) return (k == 2'b10);
    return (k == 2'b01) && (ram || mc);
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    chk(tag, "empty_n", {15'd0, empty_n}, {15'd0, q.size() != 0});
    chk(tag, "full_n", {15'd0, full_n}, {15'd0, q.size() != DEPTH});
    chk(tag, "rd_data", rd_data, m_rd);
  endtask

  // Drive one cycle at the falling edge, update the model, check after the rising edge
  task automatic cyc(input string tag, input logic v, input logic [1:0] k, input logic [15:0] d,
                     input logic ram, input logic mc, input logic rd, input logic [4:0] a,
                     input logic mw, input logic mv);
    logic pop;
    logic push;
    word_vld = v; word_kind = k; word_data = d; cmd_ram_hit = ram; cmd_mc_host = mc;
    rd_en = rd; rd_addr = a; mode_wr_en = mw; mode_wr_val = mv;
    pop  = rd && (a == 5'd0) && (q.size() != 0);
    push = keep_word(m_role, v, k, ram, mc) && ((q.size() != DEPTH) || pop);
    if (rd) m_rd = pop ? q[0] : 16'h0000;
    if (pop) void'(q.pop_front());
    if (push) q.push_back(d);
    if (mw) m_role = mv;
    @(negedge clk);
    check_outs(tag);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 2'b00, 16'h0, 0, 0, 0, 5'd0, 0, 0);
  endtask

  task automatic pop0(input string tag);
    cyc(tag, 0, 2'b00, 16'h0, 0, 0, 1, 5'd0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_outs("R1");
    // R1 / R4: role after reset is remote terminal, so a status word is dropped
    cyc("R1", 1, 2'b10, 16'hAAAA, 0, 0, 0, 5'd0, 0, 0);
    // R2: command with RAM access is stored and read back
    cyc("R2", 1, 2'b01, 16'h1111, 1, 0, 0, 5'd0, 0, 0);
    pop0("R2");
    // R3: mode code needing host stored; bare command dropped
    cyc("R3", 1, 2'b01, 16'h2222, 0, 1, 0, 5'd0, 0, 0);
    cyc("R3", 1, 2'b01, 16'h2233, 0, 0, 0, 5'd0, 0, 0);
    pop0("R3");
    pop0("R3");
    // R4: data, status, reserved never stored in remote-terminal role
    cyc("R4", 1, 2'b00, 16'h4400, 1, 1, 0, 5'd0, 0, 0);
    cyc("R4", 1, 2'b10, 16'h4410, 1, 1, 0, 5'd0, 0, 0);
    cyc("R4", 1, 2'b11, 16'h4411, 1, 1, 0, 5'd0, 0, 0);
    // R11: role change with a status word in the same cycle uses the old role
    cyc("R11", 1, 2'b10, 16'hB001, 0, 0, 0, 5'd0, 1, 1);
    // R5: bus-controller role stores status only
    cyc("R5", 1, 2'b10, 16'h5501, 0, 0, 0, 5'd0, 0, 0);
    cyc("R5", 1, 2'b01, 16'h5502, 1, 1, 0, 5'd0, 0, 0);
    cyc("R5", 1, 2'b00, 16'h5503, 1, 0, 0, 5'd0, 0, 0);
    pop0("R5");
    // R10: empty read and non-zero address read
    pop0("R10");
    cyc("R10", 1, 2'b10, 16'h7777, 0, 0, 0, 5'd0, 0, 0);
    cyc("R10", 0, 2'b00, 16'h0, 0, 0, 1, 5'd3, 0, 0);
    pop0("R10");
    // R8: fill to full, then an extra capture is dropped
    for (int i = 0; i < DEPTH; i++) cyc("R8", 1, 2'b10, 16'h8000 + 16'(i), 0, 0, 0, 5'd0, 0, 0);
    cyc("R8", 1, 2'b10, 16'hDEAD, 0, 0, 0, 5'd0, 0, 0);
    // R9: pop and capture together while full
    cyc("R9", 1, 2'b10, 16'h9999, 0, 0, 1, 5'd0, 0, 0);
    cyc("R9", 1, 2'b10, 16'h999A, 0, 0, 1, 5'd0, 0, 0);
    // R6: drain in order
    for (int i = 0; i < DEPTH + 1; i++) pop0("R6");
    // R11: back to remote terminal, status now dropped
    cyc("R11", 0, 2'b00, 16'h0, 0, 0, 0, 5'd0, 1, 0);
    cyc("R11", 1, 2'b10, 16'hC0DE, 0, 0, 0, 5'd0, 0, 0);
    idle("R7");
    // Random phases: capture-heavy then pop-heavy, with occasional role changes
    for (int n = 0; n < 6000; n++) begin
      int pr;
      logic rd;
      logic [4:0] a;
      pr = ((n / 500) % 2 == 0) ? 15 : 60;
      rd = ($urandom % 100) < pr;
      a  = (($urandom % 8) == 0) ? 5'($urandom % 32) : 5'd0;
      cyc("R6", ($urandom % 5) != 0, 2'($urandom % 4), 16'($urandom),
          1'($urandom % 2), 1'($urandom % 2), rd, a,
          ($urandom % 64) == 0, 1'($urandom % 2));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule